// File: doc/BRIEF.md
# Serial-Loaded Converter Input Register

This block is the digital front end of a 16-bit serial-input digital-to-analog converter. A host drives three lines: a serial clock, a serial data line and a latch-enable strobe. All three are brought into the faster system clock domain through a synchronizer. Every rising edge of the serial clock shifts one data bit into an input shift register, most significant bit first. Every falling edge of latch enable copies the whole shift register into a parallel holding register. The holding register is the word that the converter core would see.

The transfer is triggered only by the latch-enable edge and not by a bit count. When more than 16 serial clocks arrive between two transfers, the oldest bits drop out of the register, and only the most recent 16 are kept. The word is two's complement: 0x7FFF is positive full scale, 0x8000 is negative full scale and 0x0000 is the midpoint. The holding register resets to the midpoint.

A sticky flag reports a broken latch-enable frame. The frame is broken if latch enable falls without a serial clock rise during its high phase, or rises again without a serial clock rise during its low phase. The system clock must run at least four times faster than the serial clock.

Top module: `sdac_front`

## Requirements
- R1: During and after reset, and until the first transfer, `dac_word` is 0x0000 and `frame_err` is 0.
- R2: Each rising edge of `ser_clk` shifts the level of `ser_data` into the LSB of the shift register, and the older bits move one place toward the MSB. The first bit sent therefore ends up in bit 15.
- R3: A falling edge of `ser_le` loads `dac_word` with the last 16 bits shifted in. The word appears within 4 system clocks of the edge.
- R4: When more than 16 serial clock rises occur before a falling edge of `ser_le`, only the final 16 bits are transferred.
- R5: Serial clock edges and a rising `ser_le` leave `dac_word` unchanged. Only a falling `ser_le` changes it.
- R6: `frame_err` goes to 1 when `ser_le` falls and no serial clock rise was seen while it was high.
- R7: `frame_err` goes to 1 when `ser_le` rises and no serial clock rise was seen since it last fell.
- R8: `frame_err` stays 1 until reset. Transfers still take place while it is set, and also on the falling edge that sets it.
- R9: Words are transferred bit-exact, with no sign or offset change. This includes 0x7FFF, 0x8000, 0xFFFF and 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch enable; its falling edge transfers the word |
| dac_word | output | 16 | Parallel two's complement word for the converter core |
| frame_err | output | 1 | Sticky latch-enable framing violation flag |

## Verification
The hardest conditions to create from the ports are the framing violations, because a correctly framed stream never produces them. The bench builds them on purpose. For R6 it drops `ser_le` after a high phase that contains no serial clock. For R7 it raises `ser_le` directly after a legal falling edge. In the R6 case the bench first shifts a single bit so that the word latched on the faulty edge can be predicted. Overlong frames of 20 bits check that only the newest bits are kept. A sweep of walking-ones, walking-zeros, boundary codes and 200 pseudo-random words covers the data path.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int WORD_W = 16;

  // Shift one bit into the LSB end of a word.
  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] word, input logic b);
    return {word[WORD_W-2:0], b};
  endfunction

  // Framing rule: an edge of latch enable is legal only if a serial
  // clock rise happened in the phase that is ending (or on the same cycle).
  function automatic logic phase_bad(input logic seen, input logic rise_now);
    return !(seen || rise_now);
  endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], async_i[i]};
    end
    assign sync_o[i] = chain[STAGES-1];
    assign prev_o[i] = chain[STAGES];
  end
endmodule

// File: rtl/sdac_shreg.sv
module sdac_shreg
  import sdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_o <= '0;
    else if (shift_en) word_o <= shift_in(word_o, bit_i);
  end
endmodule

// File: rtl/sdac_frame_mon.sv
module sdac_frame_mon
  import sdac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_rise,
  input  logic le_rise,
  input  logic le_fall,
  output logic err_o
);
  logic seen_hi, seen_lo;
  logic bad_fall, bad_rise;

  assign bad_fall = le_fall && phase_bad(seen_hi, sclk_rise);
  assign bad_rise = le_rise && phase_bad(seen_lo, sclk_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_hi <= 1'b0;
      seen_lo <= 1'b1;  // latch enable is taken as low with its low phase satisfied after reset
      err_o   <= 1'b0;
    end else begin
      if (le_rise)        seen_hi <= 1'b0;
      else if (sclk_rise) seen_hi <= 1'b1;
      if (le_fall)        seen_lo <= 1'b0;
      else if (sclk_rise) seen_lo <= 1'b1;
      if (bad_fall || bad_rise) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [WORD_W-1:0] dac_word,
  output logic              frame_err
);
  logic [2:0] s_now, s_prev;
  logic       sclk_rise, le_rise, le_fall;
  logic [WORD_W-1:0] shift_q;

  sdac_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({ser_data, ser_le, ser_clk}),
    .sync_o(s_now), .prev_o(s_prev)
  );

  assign sclk_rise = s_now[0] && !s_prev[0];
  assign le_rise   = s_now[1] && !s_prev[1];
  assign le_fall   = !s_now[1] && s_prev[1];

  sdac_shreg u_shreg (
    .clk(clk), .rst_n(rst_n),
    .shift_en(sclk_rise), .bit_i(s_now[2]), .word_o(shift_q)
  );

  sdac_frame_mon u_mon (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .le_rise(le_rise), .le_fall(le_fall),
    .err_o(frame_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dac_word <= '0;
    else if (le_fall) dac_word <= shift_q;
  end
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk
  import sdac_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_rise,
  input logic              le_fall,
  input logic [WORD_W-1:0] shift_q,
  input logic [WORD_W-1:0] dac_word,
  input logic              frame_err
);
  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shift_q[WORD_W-1:1] == $past(shift_q[WORD_W-2:0]));
  assert_shift_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(shift_q));
  assert_latch_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    le_fall |=> dac_word == $past(shift_q));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !le_fall |=> $stable(dac_word));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);
endmodule

bind sdac_front sdac_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .le_fall(le_fall),
  .shift_q(shift_q), .dac_word(dac_word), .frame_err(frame_err)
);

// File: tb/sdac_front_test.sv
module sdac_front_test;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_data = 0, ser_le = 0;
  logic [15:0] dac_word;
  logic frame_err;
  int errors = 0, checks = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  sdac_front uut (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
                  .ser_le(ser_le), .dac_word(dac_word), .frame_err(frame_err));

  always #5 clk = ~clk;

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_data = b; ser_clk = 0; wait_cyc(4);
    ser_clk = 1; wait_cyc(4);
    ser_clk = 0;
  endtask

  // First bit with latch enable low, raise it, remaining bits, then drop it.
  task automatic frame(input logic [15:0] w, input int extra);
    for (int i = extra - 1; i >= 0; i--) send_bit(lfsr[i % 16]);
    send_bit(w[15]);
    ser_le = 1; wait_cyc(2);
    for (int i = 14; i >= 0; i--) send_bit(w[i]);
    ser_le = 0; wait_cyc(8);
  endtask

  task automatic do_reset;
    rst_n = 0; ser_le = 0; ser_clk = 0; wait_cyc(4);
    rst_n = 1; wait_cyc(4);
  endtask

  initial begin
    wait_cyc(150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 word", dac_word, 16'h0000);
    check("R1 flag", {15'd0, frame_err}, 16'd0);

    // Bit-exact boundary codes
    frame(16'h7FFF, 0); check("R9 +full", dac_word, 16'h7FFF);
    frame(16'h8000, 0); check("R9 -full", dac_word, 16'h8000);
    frame(16'hFFFF, 0); check("R9 minus1", dac_word, 16'hFFFF);
    frame(16'h0000, 0); check("R9 mid", dac_word, 16'h0000);

    // Walking ones and zeros: MSB-first placement
    for (int k = 0; k < 16; k++) begin
      frame(16'h1 << k, 0); check("R2 walk1", dac_word, 16'h1 << k);
      frame(~(16'h1 << k), 0); check("R3 walk0", dac_word, ~(16'h1 << k));
    end

    // Pseudo-random words, some with excess leading clocks
    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      frame(lfsr ^ 16'h5A5A, (n % 3 == 0) ? 4 : 0);
      check((n % 3 == 0) ? "R4 excess" : "R3 random", dac_word, lfsr ^ 16'h5A5A);
    end
    check("R6 no flag on legal frames", {15'd0, frame_err}, 16'd0);

    // Holding register ignores shifting and a rising latch enable
    frame(16'h1234, 0);
    send_bit(1'b1);
    ser_le = 1; wait_cyc(2);
    for (int i = 0; i < 8; i++) send_bit(i[0]);
    check("R5 hold during shift", dac_word, 16'h1234);
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    ser_le = 0; wait_cyc(8);
    check("R5 no flag", {15'd0, frame_err}, 16'd0);

    // R6: high phase without a serial clock
    frame(16'hC3A5, 0);
    send_bit(1'b1);
    ser_le = 1; wait_cyc(8);
    ser_le = 0; wait_cyc(8);
    check("R6 flag", {15'd0, frame_err}, 16'd1);
    check("R8 transfer on bad edge", dac_word, 16'h874B);
    frame(16'h2468, 0);
    check("R8 sticky", {15'd0, frame_err}, 16'd1);
    check("R8 transfer while set", dac_word, 16'h2468);

    // R7: low phase without a serial clock
    do_reset();
    check("R1 flag after reset", {15'd0, frame_err}, 16'd0);
    check("R1 word after reset", dac_word, 16'h0000);
    frame(16'h0F0F, 0);
    check("R7 no flag yet", {15'd0, frame_err}, 16'd0);
    ser_le = 1; wait_cyc(8);
    check("R7 flag", {15'd0, frame_err}, 16'd1);
    check("R5 rise keeps word", dac_word, 16'h0F0F);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule